// File: doc/BRIEF.md
# Byte Queue with Latched Error Flags

This block is a single-clock, first-in first-out byte queue. It holds 2**ADDR_W entries in a circular store. The oldest stored byte is always on `head_byte` ahead of any read request. A consumer can therefore sample the byte and pop it in the same cycle, with no extra latency. Producers push with `wr_en` and consumers pop with `rd_next`. The block reports the current occupancy and whether any data is waiting.

Misuse is recorded rather than hidden. A push into a full queue loses its byte and raises `ovf_flag`. A pop from an empty queue raises `udf_flag`. Both flags latch until they are explicitly cleared. The block has two separate clear inputs. `rst` empties the queue and drops the flags. `clr_err` drops only the flags and leaves the stored bytes, the occupancy and the head byte untouched. All outputs are registered and change on the clock edge that accepts the operation.

Top module: `sticky_byte_fifo`

## Requirements
- R1: A cycle with `rst` high leaves `fill_count` = 0, `has_data` = 0, `head_byte` = 0, and both flags at 0 after the edge. `rst` overrides every other input, and a push in that cycle is not stored.
- R2: The capacity is DEPTH = 2**ADDR_W. An accepted push adds one to `fill_count` and an accepted pop subtracts one. When a push and a pop are both accepted, `fill_count` stays the same. Each change is visible right after the accepting edge.
- R3: While `has_data` is 1, `head_byte` equals the oldest stored byte. It is updated on the same edge as a push into an empty queue or a pop, and this includes a push into the slot that becomes the head in that same cycle.
- R4: `has_data` is 1 exactly when `fill_count` is nonzero.
- R5: A push while `fill_count` = DEPTH with no pop in the same cycle sets `ovf_flag`, discards the byte and leaves `fill_count` unchanged. A push together with a pop on a full queue is accepted, and `ovf_flag` is not set.
- R6: A pop while `fill_count` = 0 sets `udf_flag` and does not advance the read position. A push in the same cycle is still stored and becomes `head_byte`.
- R7: Each flag stays at 1 until `rst` or `clr_err` is high at an edge. `clr_err` clears both flags without changing `fill_count`, `has_data` or `head_byte`, and it wins over a new error in the same cycle.
- R8: Bytes leave in the order they were accepted, including across the wrap of the circular store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset: empties the queue and clears the flags |
| clr_err | input | 1 | Clears both error flags and keeps the stored data |
| wr_en | input | 1 | Push `wr_byte` this cycle |
| wr_byte | input | DATA_W | Byte to push |
| rd_next | input | 1 | Pop the current head byte this cycle |
| head_byte | output | DATA_W | Oldest stored byte, prefetched |
| has_data | output | 1 | At least one byte is stored |
| ovf_flag | output | 1 | Latched: a push was attempted while full |
| udf_flag | output | 1 | Latched: a pop was attempted while empty |
| fill_count | output | ADDR_W+1 | Number of stored bytes, 0 to DEPTH |

## Verification
The bench builds the queue with ADDR_W = 2, so it holds four bytes. Full, overflow and the wrap of both positions are therefore reached within a handful of pushes, and every stored byte can be traced by hand. Filling the queue completely in a four-entry store sends the write position round the ring, so the order and bypass checks cover reuse of slots. With this small depth, a push into the slot that becomes the new head in the same cycle occurs both on an empty queue and on a one-entry queue being popped.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  // Decision made by the pointer controller for the current cycle
  typedef struct packed {
    logic wr_ok;    // push accepted and stored
    logic rd_ok;    // pop accepted, read position advances
    logic ovf_evt;  // push refused because the store is full
    logic udf_evt;  // pop refused because the store is empty
  } sbf_acc_t;

  localparam int unsigned SBF_NFLAGS = 2;
  localparam int unsigned SBF_OVF = 0;
  localparam int unsigned SBF_UDF = 1;

endpackage

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import sbf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  output sbf_acc_t          acc,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr_nxt,
  output logic [ADDR_W:0]   count,
  output logic              not_empty
);
  localparam int unsigned CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(2 ** ADDR_W);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ONE_PTR = ADDR_W'(1);

  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [CNT_W-1:0]  count_nxt;
  logic              is_full;
  logic              is_empty;

  assign is_full  = (count == FULL_CNT);
  assign is_empty = (count == '0);

  always_comb begin
    acc         = '0;
    acc.rd_ok   = rd_req && !is_empty && !rst;
    acc.wr_ok   = wr_req && (!is_full || acc.rd_ok) && !rst;
    acc.ovf_evt = wr_req && is_full && !acc.rd_ok && !rst;
    acc.udf_evt = rd_req && is_empty && !rst;
  end

  assign wr_addr     = wr_ptr;
  assign rd_addr_nxt = rst ? '0 : (acc.rd_ok ? rd_ptr + ONE_PTR : rd_ptr);

  always_comb begin
    count_nxt = count;
    if (acc.wr_ok && !acc.rd_ok) count_nxt = count + ONE_CNT;
    else if (acc.rd_ok && !acc.wr_ok) count_nxt = count - ONE_CNT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      not_empty <= 1'b0;
    end else begin
      if (acc.wr_ok) wr_ptr <= wr_ptr + ONE_PTR;
      if (acc.rd_ok) rd_ptr <= rd_ptr + ONE_PTR;
      count     <= count_nxt;
      not_empty <= (count_nxt != '0);
    end
  end

  // R2: occupancy never exceeds capacity
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R6: refused pop leaves the read position in place
  a_r6_rd_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (is_empty && rd_req) |=> $stable(rd_ptr));

  // R2: simultaneous accepted push and pop keeps occupancy
  a_r2_both_stable: assert property (@(posedge clk) disable iff (rst)
    (acc.wr_ok && acc.rd_ok) |=> $stable(count));

endmodule

// File: rtl/sbf_store.sv
module sbf_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] head
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              fwd;

  // Plain synchronous write port, no reset: maps onto a RAM block
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read of the next head address; bypass when the head slot
  // is being written in this very cycle
  assign fwd = we && (waddr == raddr);

  always_ff @(posedge clk) begin
    if (rst) head <= '0;
    else if (fwd) head <= wdata;
    else head <= mem[raddr];
  end

endmodule

// File: rtl/sbf_flags.sv
module sbf_flags
  import sbf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [SBF_NFLAGS-1:0] evt,
  output logic [SBF_NFLAGS-1:0] flag
);
  for (genvar i = 0; i < SBF_NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr) flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
    end

    // R7: a raised flag holds until a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !clr) |=> flag[i]);

    // R7: clear dominates a coincident event
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
      clr |=> !flag[i]);
  end

endmodule

// File: rtl/sticky_byte_fifo.sv
module sticky_byte_fifo
  import sbf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_err,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_next,
  output logic [DATA_W-1:0] head_byte,
  output logic              has_data,
  output logic              ovf_flag,
  output logic              udf_flag,
  output logic [ADDR_W:0]   fill_count
);
  localparam int unsigned CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(2 ** ADDR_W);

  sbf_acc_t              acc;
  logic [ADDR_W-1:0]     wr_addr;
  logic [ADDR_W-1:0]     rd_addr_nxt;
  logic [SBF_NFLAGS-1:0] evt;
  logic [SBF_NFLAGS-1:0] flags;

  sbf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (wr_en),
    .rd_req     (rd_next),
    .acc        (acc),
    .wr_addr    (wr_addr),
    .rd_addr_nxt(rd_addr_nxt),
    .count      (fill_count),
    .not_empty  (has_data)
  );

  sbf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (acc.wr_ok),
    .waddr(wr_addr),
    .wdata(wr_byte),
    .raddr(rd_addr_nxt),
    .head (head_byte)
  );

  always_comb begin
    evt          = '0;
    evt[SBF_OVF] = acc.ovf_evt;
    evt[SBF_UDF] = acc.udf_evt;
  end

  sbf_flags u_flags (
    .clk (clk),
    .rst (rst),
    .clr (clr_err),
    .evt (evt),
    .flag(flags)
  );

  assign ovf_flag = flags[SBF_OVF];
  assign udf_flag = flags[SBF_UDF];

  // R1: reset empties the queue and drops the flags
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fill_count == '0 && !has_data && !ovf_flag && !udf_flag));

  // R4: ready indication agrees with occupancy
  a_r4_has_data: assert property (@(posedge clk) disable iff (rst)
    has_data == (fill_count != '0));

  // R5: push into full queue without pop raises overflow, count held
  a_r5_overflow: assert property (@(posedge clk) disable iff (rst)
    (fill_count == FULL_CNT && wr_en && !rd_next && !clr_err)
      |=> (ovf_flag && fill_count == FULL_CNT));

  // R6: pop from empty queue raises underflow
  a_r6_underflow: assert property (@(posedge clk) disable iff (rst)
    (fill_count == '0 && rd_next && !clr_err) |=> udf_flag);

  // R7: flag clear keeps stored data
  a_r7_clear_keeps: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !wr_en && !rd_next)
      |=> ($stable(fill_count) && $stable(head_byte)));

endmodule

// File: tb/sticky_byte_fifo_test.sv
module sticky_byte_fifo_test;
  localparam int unsigned AW = 2;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          clr_err;
  logic          wr_en;
  logic [DW-1:0] wr_byte;
  logic          rd_next;
  logic [DW-1:0] head_byte;
  logic          has_data;
  logic          ovf_flag;
  logic          udf_flag;
  logic [AW:0]   fill_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sticky_byte_fifo #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .clr_err(clr_err), .wr_en(wr_en),
    .wr_byte(wr_byte), .rd_next(rd_next), .head_byte(head_byte),
    .has_data(has_data), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
    .fill_count(fill_count)
  );

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic       clr;
    logic [7:0] din;
    logic [2:0] cnt;
    logic       hv;
    logic [7:0] head;
    logic       ovf;
    logic       udf;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,8'h00,3'd0,1'b0,8'h00,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,8'h00,3'd0,1'b0,8'h00,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,8'hA1,3'd1,1'b1,8'hA1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,8'hB2,3'd2,1'b1,8'hA1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,8'hC3,3'd3,1'b1,8'hA1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,8'hD4,3'd4,1'b1,8'hA1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,8'hE5,3'd4,1'b1,8'hA1,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,8'h00,3'd3,1'b1,8'hB2,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,8'hF6,3'd3,1'b1,8'hC3,1'b1,1'b0},
    '{1'b0,1'b0,1'b1,8'h00,3'd3,1'b1,8'hC3,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,8'h00,3'd2,1'b1,8'hD4,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,8'h00,3'd1,1'b1,8'hF6,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,8'h00,3'd0,1'b0,8'h00,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,8'h77,3'd1,1'b1,8'h77,1'b0,1'b1},
    '{1'b1,1'b1,1'b0,8'h88,3'd1,1'b1,8'h88,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,8'h00,3'd1,1'b1,8'h88,1'b0,1'b0}
  };

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic w, input logic r, input logic c, input logic [7:0] d);
    wr_en = w; rd_next = r; clr_err = c; wr_byte = d;
    @(negedge clk);
    wr_en = 1'b0; rd_next = 1'b0; clr_err = 1'b0; wr_byte = '0;
  endtask

  task automatic expect_state(input string tag, input int cnt, input int hv, input int ovf, input int udf);
    check($sformatf("R2 %s fill_count", tag), int'(fill_count), cnt);
    check($sformatf("R4 %s has_data", tag), int'(has_data), hv);
    check($sformatf("R5 %s ovf_flag", tag), int'(ovf_flag), ovf);
    check($sformatf("R6 %s udf_flag", tag), int'(udf_flag), udf);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr_err = 1'b0; wr_en = 1'b0; rd_next = 1'b0; wr_byte = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset fill_count", int'(fill_count), 0);
    check("R1 reset has_data", int'(has_data), 0);
    check("R1 reset head_byte", int'(head_byte), 0);
    check("R1 reset flags", int'({ovf_flag, udf_flag}), 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].rd, VECS[i].clr, VECS[i].din);
      expect_state($sformatf("vec%0d", i), int'(VECS[i].cnt), int'(VECS[i].hv),
                   int'(VECS[i].ovf), int'(VECS[i].udf));
      if (VECS[i].hv)
        check($sformatf("R3 vec%0d head_byte", i), int'(head_byte), int'(VECS[i].head));
    end

    // R1: reset with a push pending stores nothing
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0, 8'h5A);
    rst = 1'b0;
    expect_state("R1 mid-data reset", 0, 0, 0, 0);
    check("R1 mid-data reset head_byte", int'(head_byte), 0);

    // R5: fill completely, then push+pop while full is accepted
    step(1'b1, 1'b0, 1'b0, 8'h11);
    step(1'b1, 1'b0, 1'b0, 8'h22);
    step(1'b1, 1'b0, 1'b0, 8'h33);
    step(1'b1, 1'b0, 1'b0, 8'h44);
    expect_state("R5 full", 4, 1, 0, 0);
    step(1'b1, 1'b1, 1'b0, 8'h55);
    expect_state("R5 push+pop full", 4, 1, 0, 0);
    check("R5 push+pop full head_byte", int'(head_byte), 8'h22);

    // R8: drain in order across the wrap
    check("R8 order 0", int'(head_byte), 8'h22);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 order 1", int'(head_byte), 8'h33);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 order 2", int'(head_byte), 8'h44);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 order 3", int'(head_byte), 8'h55);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    expect_state("R8 drained", 0, 0, 0, 0);

    // R7: clear in the same cycle as a refused pop wins
    step(1'b0, 1'b1, 1'b1, 8'h00);
    check("R7 clear beats new underflow", int'(udf_flag), 0);

    // R7: underflow stays set over idle cycles, then reset clears it
    step(1'b0, 1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check("R7 underflow held", int'(udf_flag), 1);
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0, 8'h00);
    rst = 1'b0;
    check("R7 reset clears underflow", int'(udf_flag), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule